// File: doc/BRIEF.md
# Hold-Mode Wake-Up Flag Controller

This block sits beside a small controller that can park itself in a low-power hold state. It watches ten input pins in three groups and decides which pin activity may end the hold state. A four-pin general group (port C) wakes the controller on any transition and can also raise an interrupt. A four-pin wake-only group (port D) wakes it on any transition, never interrupts, and also sets a hidden latch. Two further pins (port 1, pins 2 and 3) wake it on falling edges only. Software picks the pins that take part through two write-only enable registers.

Hardware records each wake-up cause in a sticky 8-bit status register, which software reads as two nibbles and clears by writing a bit mask. Clearing an enable also clears the status bit that the enable feeds, in the same cycle. The hidden port D latch keeps the wake request alive until software clears it through its own write operation. The wake request drives a one-cycle release pulse, but only while the controller reports that it is in hold.

Top module: `wake_flag_ctrl`

## Requirements
- R1: After reset both enable registers, all status bits and the hidden port D latch are zero, so `rd_data` reads 0 for both nibbles and `release_pulse` and `pc_irq` are low.
- R2: With port enable bit i (i = 0..3) set, a rising or a falling transition on `pc_in[i]` sets status bit i. The bit reads 1 no later than four clock edges after the pin changes, counting two synchronizer stages, the edge detector and the flag.
- R3: A pin whose enable bit is 0 never sets any status bit and never causes a release pulse.
- R4: With port enable bit 4+j (j = 0..3) set, any transition on `pd_in[j]` sets status bit 4 and the hidden latch. Port D activity never raises `pc_irq`.
- R5: The port 1 enable register (`wr_sel` = 1) uses only `wr_data[2]`, which enables `p1_in[0]`, and `wr_data[3]`, which enables `p1_in[1]`. A falling edge on an enabled pin sets status bit 5 (for `p1_in[0]`) or status bit 6 (for `p1_in[1]`). A rising edge has no effect.
- R6: `pc_irq` is high exactly while at least one of status bits 0 to 3 is set.
- R7: `release_pulse` is high for exactly one cycle each time the wake level (the OR of all status bits and the hidden latch), qualified by `hold_active`, goes from 0 to 1. If a flag is already pending when `hold_active` rises, the pulse comes at that time. There is no pulse while `hold_active` is low.
- R8: A write with `wr_sel` = 2 clears each status bit whose `wr_data` bit is 1 and leaves the hidden latch unchanged.
- R9: Only a write with `wr_sel` = 3 clears the hidden latch. While the latch is set, the wake level stays high, so clearing status bit 4 alone gives no new release pulse for later port D events.
- R10: A write with `wr_sel` = 0 loads the port enable register from `wr_data[7:0]`. In the same cycle it clears status bit i for every `wr_data[i]` = 0 (i = 0..3), and it clears status bit 4 when `wr_data[7:4]` is all zero. A `wr_sel` = 1 write with `wr_data[2]` = 0 clears status bit 5, and with `wr_data[3]` = 0 it clears status bit 6.
- R11: When a wake event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R12: `rd_data` shows status bits 3:0 when `rd_nibble_sel` = 0 and status bits 7:4 when it is 1. Bit 7 always reads 0. Reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_active | input | 1 | Controller is in the hold state |
| pc_in | input | 4 | Port C pins: wake and interrupt on any change |
| pd_in | input | 4 | Port D pins: wake only, on any change |
| p1_in | input | 2 | Port 1 pins 2 and 3: wake on a falling edge |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write operation: 0 port enable, 1 port-1 enable, 2 status clear mask, 3 clear the hidden latch |
| wr_data | input | 8 | Write data |
| rd_nibble_sel | input | 1 | 0 selects the low status nibble, 1 the high nibble |
| rd_data | output | 4 | Selected status nibble |
| release_pulse | output | 1 | One-cycle hold-release pulse |
| pc_irq | output | 1 | Port C change interrupt request |

## Verification
The hardest case to reach is a wake event and a software clear of the same status bit landing in the same cycle, because the event sits behind two synchronizer stages and an edge register. The bench changes a pin on a falling clock edge, waits exactly two more falling edges, and then holds the clear strobe across the rising edge at which the detected change reaches the flag. It then checks that the bit is still set. The hidden port D latch can only be seen through the pulse count, so the bench clears the visible status bit, fires port D again, and confirms that no new release pulse appears until the latch's own clear has been written.

// File: rtl/wake_flag_pkg.sv
// Shared widths, status bit positions and write operation codes for the
// hold-mode wake-up flag controller.
package wake_flag_pkg;
    localparam int PC_W   = 4;            // port C pins
    localparam int PD_W   = 4;            // port D pins
    localparam int P1_W   = 2;            // port 1 wake pins (pins 2 and 3)
    localparam int EN_W   = PC_W + PD_W;  // port enable register width
    localparam int ST_W   = 8;            // status register width
    localparam int NIB_W  = ST_W / 2;     // read nibble width
    localparam int ST_PD  = PC_W;         // status bit for port D
    localparam int ST_P1  = PC_W + 1;     // first status bit for port 1
    localparam int P1_LSB = 2;            // wr_data bit of the first port 1 enable
    localparam int IN_W   = PC_W + PD_W + P1_W;

    typedef enum logic [1:0] {
        OP_PORT_EN = 2'd0,
        OP_P1_EN   = 2'd1,
        OP_CLR_ST  = 2'd2,
        OP_CLR_PD  = 2'd3
    } wr_op_e;
endpackage

// File: rtl/wf_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes STAGES >= 2; every stage resets to zero synchronously.
module wf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wf_change_det.sv
// Edge detector on synchronized signals. FALL_ONLY = 0 flags any change,
// FALL_ONLY = 1 flags only a 1-to-0 transition.
// Assumes cur is already synchronous to clk; the previous sample resets to 0.
module wf_change_det #(
    parameter int W         = 1,
    parameter bit FALL_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev;

    // Hold the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    generate
        if (FALL_ONLY) begin : g_fall
            assign evt = prev & ~cur;
        end else begin : g_any
            assign evt = prev ^ cur;
        end
    endgenerate
endmodule

// File: rtl/wf_flag_bank.sv
// Bank of sticky flags: set by hardware and cleared by software.
// A set and a clear of the same bit in one cycle leave the bit set.
module wf_flag_bank #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // Apply clears first, then sets, so that a set always wins.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/wf_release_gen.sv
// Turns the wake level into a one-cycle release pulse, qualified by the
// hold indication. Assumes hold_active is synchronous to clk.
module wf_release_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_active,
    input  logic wake_lvl,
    output logic release_pulse
);
    logic armed;
    logic armed_q;

    assign armed = hold_active & wake_lvl;

    // Remember the qualified wake level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed;
    end

    assign release_pulse = armed & ~armed_q;
endmodule

// File: rtl/wake_flag_ctrl.sv
// Hold-mode wake-up flag controller (top).
// Synchronizes port C, port D and port 1 pins, detects enabled changes,
// records causes in sticky status flags plus a hidden port D latch, and
// produces a hold-release pulse and a port C interrupt request.
// Assumes write and read controls are synchronous to clk.
module wake_flag_ctrl
    import wake_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_active,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [PD_W-1:0]  pd_in,
    input  logic [P1_W-1:0]  p1_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             rd_nibble_sel,
    output logic [NIB_W-1:0] rd_data,
    output logic             release_pulse,
    output logic             pc_irq
);
    wr_op_e           wr_op;
    logic [IN_W-1:0]  pins_sync;
    logic [EN_W-1:0]  chg_evt;
    logic [P1_W-1:0]  fall_evt;
    logic [EN_W-1:0]  pen_q;
    logic [P1_W-1:0]  p1en_q;
    logic [ST_W-1:0]  status_q;
    logic [ST_W-1:0]  st_set;
    logic [ST_W-1:0]  st_clr;
    logic             pd_flag;
    logic             pd_set;
    logic             pd_clr;
    logic             wake_lvl;

    assign wr_op = wr_op_e'(wr_sel);

    wf_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({p1_in, pd_in, pc_in}),
        .q     (pins_sync)
    );

    wf_change_det #(.W(EN_W), .FALL_ONLY(1'b0)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (pins_sync[EN_W-1:0]),
        .evt   (chg_evt)
    );

    wf_change_det #(.W(P1_W), .FALL_ONLY(1'b1)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (pins_sync[IN_W-1:EN_W]),
        .evt   (fall_evt)
    );

    // Load the two write-only enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q  <= '0;
            p1en_q <= '0;
        end else if (wr_en) begin
            if (wr_op == OP_PORT_EN) pen_q  <= wr_data[EN_W-1:0];
            if (wr_op == OP_P1_EN)   p1en_q <= wr_data[P1_LSB +: P1_W];
        end
    end

    // Map masked pin events onto status bit set requests.
    always_comb begin
        st_set                  = '0;
        st_set[PC_W-1:0]        = chg_evt[PC_W-1:0] & pen_q[PC_W-1:0];
        st_set[ST_PD]           = |(chg_evt[EN_W-1:PC_W] & pen_q[EN_W-1:PC_W]);
        st_set[ST_P1 +: P1_W]   = fall_evt & p1en_q;
    end

    // Build clear requests from the clear mask and from disabling writes.
    always_comb begin
        st_clr = '0;
        if (wr_en) begin
            case (wr_op)
                OP_CLR_ST:  st_clr = wr_data[ST_W-1:0];
                OP_PORT_EN: begin
                    st_clr[PC_W-1:0] = ~wr_data[PC_W-1:0];
                    st_clr[ST_PD]    = ~|wr_data[EN_W-1:PC_W];
                end
                OP_P1_EN:   st_clr[ST_P1 +: P1_W] = ~wr_data[P1_LSB +: P1_W];
                default:    st_clr = '0;
            endcase
        end
    end

    wf_flag_bank #(.W(ST_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (st_set),
        .clr   (st_clr),
        .q     (status_q)
    );

    assign pd_set = st_set[ST_PD];
    assign pd_clr = wr_en && (wr_op == OP_CLR_PD);

    wf_flag_bank #(.W(1)) u_pd_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pd_set),
        .clr   (pd_clr),
        .q     (pd_flag)
    );

    assign wake_lvl = (|status_q) | pd_flag;

    wf_release_gen u_rel (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_active   (hold_active),
        .wake_lvl      (wake_lvl),
        .release_pulse (release_pulse)
    );

    assign pc_irq  = |status_q[PC_W-1:0];
    assign rd_data = rd_nibble_sel ? status_q[ST_W-1 -: NIB_W] : status_q[NIB_W-1:0];
endmodule

// File: rtl/wake_flag_ctrl_chk.sv
// Assertion checker for the wake-up flag controller, bound to the top.
module wake_flag_ctrl_chk
    import wake_flag_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            hold_active,
    input logic            release_pulse,
    input logic            pc_irq,
    input logic [ST_W-1:0] status_q,
    input logic [ST_W-1:0] st_set,
    input logic [EN_W-1:0] pen_q,
    input logic            pd_flag,
    input logic            pd_clr
);
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> !release_pulse);

    a_r7_pulse_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> hold_active);

    a_r3_pc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q[PC_W-1:0] & ~$past(status_q[PC_W-1:0])
                   & ~$past(pen_q[PC_W-1:0])) == '0));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_set) |=> (($past(st_set) & ~status_q) == '0));

    a_r4_pd_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (st_set[PC_W-1:0] == '0 && !pc_irq) |=> !pc_irq);

    a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_flag && !pd_clr) |=> pd_flag);
endmodule

bind wake_flag_ctrl wake_flag_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold_active   (hold_active),
    .release_pulse (release_pulse),
    .pc_irq        (pc_irq),
    .status_q      (status_q),
    .st_set        (st_set),
    .pen_q         (pen_q),
    .pd_flag       (pd_flag),
    .pd_clr        (pd_clr)
);

// File: tb/wake_flag_ctrl_tb.sv
`timescale 1ns/1ps
module wake_flag_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_active = 1'b0;
    logic [3:0] pc_in = 4'h0;
    logic [3:0] pd_in = 4'h0;
    logic [1:0] p1_in = 2'b11;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_nibble_sel = 1'b0;
    logic [3:0] rd_data;
    logic       release_pulse;
    logic       pc_irq;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int exp_pulses = 0;

    always #4 clk = ~clk;

    wake_flag_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_active   (hold_active),
        .pc_in         (pc_in),
        .pd_in         (pd_in),
        .p1_in         (p1_in),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .rd_nibble_sel (rd_nibble_sel),
        .rd_data       (rd_data),
        .release_pulse (release_pulse),
        .pc_irq        (pc_irq)
    );

    // Count clock cycles in which the release pulse is high.
    always @(posedge clk) if (rst_n && release_pulse) pulses++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic hi, output int val);
        rd_nibble_sel = hi;
        #1 val = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(1'b0, v); chk("R1 low nibble", v, 0);
        rd(1'b1, v); chk("R1 high nibble", v, 0);
        chk("R1 irq", pc_irq, 0);
        chk("R1 release", release_pulse, 0);
        chk("R1 pulse count", pulses, 0);
    endtask

    task automatic t_portc();
        int v;
        hold_active = 1'b1;
        wr(2'd0, 8'h05);
        @(negedge clk); pc_in[1] = 1'b1; settle();
        rd(1'b0, v); chk("R3 disabled pc pin", v, 0);
        chk("R3 no pulse", pulses, exp_pulses);
        @(negedge clk); pc_in[0] = 1'b1; settle();
        exp_pulses++;
        rd(1'b0, v); chk("R2 pc rise", v, 1);
        chk("R6 irq set", pc_irq, 1);
        chk("R7 pulse on pc", pulses, exp_pulses);
        wr(2'd2, 8'h01); #1;
        rd(1'b0, v); chk("R8 clear mask", v, 0);
        chk("R6 irq cleared", pc_irq, 0);
        @(negedge clk); pc_in[0] = 1'b0; settle();
        exp_pulses++;
        rd(1'b0, v); chk("R2 pc fall", v, 1);
        chk("R7 second pulse", pulses, exp_pulses);
        @(negedge clk); pc_in[2] = 1'b1; settle();
        rd(1'b0, v); chk("R2 pc pin2", v, 5);
        wr(2'd2, 8'hFF);
    endtask

    task automatic t_portd();
        int v;
        wr(2'd0, 8'h20);
        @(negedge clk); pd_in[0] = 1'b1; settle();
        rd(1'b1, v); chk("R3 disabled pd pin", v, 0);
        @(negedge clk); pd_in[1] = 1'b1; settle();
        exp_pulses++;
        rd(1'b1, v); chk("R4 pd sets bit4", v, 1);
        chk("R4 no irq from pd", pc_irq, 0);
        chk("R4 pulse", pulses, exp_pulses);
        wr(2'd2, 8'h10);
        rd(1'b1, v); chk("R8 bit4 cleared", v, 0);
        @(negedge clk); pd_in[1] = 1'b0; settle();
        rd(1'b1, v); chk("R4 pd again", v, 1);
        chk("R9 latch blocks pulse", pulses, exp_pulses);
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h00);
        @(negedge clk); pd_in[1] = 1'b1; settle();
        exp_pulses++;
        chk("R9 pulse after latch clear", pulses, exp_pulses);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_port1();
        int v;
        wr(2'd1, 8'h04);
        @(negedge clk); p1_in[0] = 1'b0; settle();
        exp_pulses++;
        rd(1'b1, v); chk("R5 p1 pin2 fall", v, 2);
        chk("R5 pulse", pulses, exp_pulses);
        wr(2'd2, 8'h20);
        @(negedge clk); p1_in[0] = 1'b1; settle();
        rd(1'b1, v); chk("R5 rise ignored", v, 0);
        @(negedge clk); p1_in[1] = 1'b0; settle();
        rd(1'b1, v); chk("R3 p1 pin3 disabled", v, 0);
        wr(2'd1, 8'h0C);
        @(negedge clk); p1_in[1] = 1'b1; settle();
        @(negedge clk); p1_in[1] = 1'b0; settle();
        exp_pulses++;
        rd(1'b1, v); chk("R5 p1 pin3 fall", v, 4);
        wr(2'd2, 8'hFF);
        @(negedge clk); p1_in[1] = 1'b1; settle();
    endtask

    task automatic t_enable_clear();
        int v;
        wr(2'd0, 8'hFF);
        @(negedge clk); pc_in[3] = 1'b1; pd_in[2] = 1'b1; p1_in[0] = 1'b0; settle();
        exp_pulses++;
        rd(1'b0, v); chk("R10 setup low", v, 8);
        rd(1'b1, v); chk("R10 setup high", v, 3);
        wr(2'd0, 8'hF7);
        rd(1'b0, v); chk("R10 pc disable clears", v, 0);
        rd(1'b1, v); chk("R10 pd still enabled", v, 3);
        wr(2'd0, 8'h07);
        rd(1'b1, v); chk("R10 pd disable clears", v, 2);
        wr(2'd1, 8'h08);
        rd(1'b1, v); chk("R10 p1 disable clears", v, 0);
        wr(2'd3, 8'h00);
        @(negedge clk); p1_in[0] = 1'b1; settle();
        chk("R7 pulse total", pulses, exp_pulses);
    endtask

    task automatic t_set_wins();
        int v;
        wr(2'd0, 8'h01);
        @(negedge clk); pc_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        settle();
        exp_pulses++;
        rd(1'b0, v); chk("R11 set beats clear", v, 1);
        wr(2'd2, 8'h01);
        rd(1'b0, v); chk("R8 later clear", v, 0);
    endtask

    task automatic t_hold();
        int v;
        hold_active = 1'b0;
        @(negedge clk); pc_in[0] = 1'b0; settle();
        rd(1'b0, v); chk("R7 flag while awake", v, 1);
        chk("R7 no pulse out of hold", pulses, exp_pulses);
        @(negedge clk); hold_active = 1'b1;
        @(negedge clk); @(negedge clk);
        exp_pulses++;
        chk("R7 pulse on hold entry", pulses, exp_pulses);
        rd(1'b1, v); chk("R12 high nibble read", v, 0);
        rd(1'b0, v); chk("R12 read no side effect", v, 1);
        wr(2'd2, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_portc();
        t_portd();
        t_port1();
        t_enable_clear();
        t_set_wins();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule